// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Model

This block is a clock-sampled behavioural model of a 16-bit static-style memory that is accessed through an asynchronous control interface. The control inputs are chip select, write strobe, output gate and one enable for each byte lane, all active low. Every clock cycle the block samples them and decodes one of four modes: deselected, read, outputs off, or write. The data bus is not modelled as a tri-state net. Instead it appears as a read-data vector plus one drive-enable bit for each byte lane, so a testbench can see at the ports which lanes would be driving and which would be floating.

A write is not committed while its enables are asserted. The block stores it on the first sampled cycle in which the overlap of chip select, write strobe and at least one byte enable has ended. Any of those signals may be the one that ends it. The address, data and lane mask that are stored are the ones held in the last cycle of the overlap, so the bus may change as the write is released. The storage depth comes from the address-width parameter: 17 bits gives the full 128K words, and the default is kept small for simulation. Contents are undefined after reset.

Top module: `bml_top`

## Requirements
- R1: When `cs_n` is 1, or when `hi_be_n` and `lo_be_n` are both 1, `rdata_en` is 2'b00 regardless of the other controls.
- R2: With `cs_n`=0, `we_n`=1 and `oe_n`=0, `rdata_en[0]` equals the inverse of `lo_be_n` and `rdata_en[1]` equals the inverse of `hi_be_n`. An enabled lane presents the stored byte of the addressed word: lane 0 on bits 7:0 and lane 1 on bits 15:8.
- R3: With `cs_n`=0, `we_n`=1 and `oe_n`=1, `rdata_en` is 2'b00.
- R4: While `cs_n` and `we_n` are both 0, `rdata_en` is 2'b00 whatever the value of `oe_n`.
- R5: A write commits on the first sampled cycle in which the write overlap (`cs_n`=0, `we_n`=0, at least one byte enable 0) is false after being true. It commits whether `we_n` rising, `cs_n` rising or both byte enables rising ends the overlap. A read in the following cycle returns the new data.
- R6: The committed address, data and lane mask are those sampled in the last cycle of the overlap. Values presented in earlier overlap cycles, and values presented in the terminating cycle, have no effect.
- R7: Only lanes whose byte enable was 0 in the last overlap cycle are written. The other lane of that word keeps its previous byte.
- R8: A lane whose `rdata_en` bit is 0 shows all zeros on its `rdata` bits.
- R9: A write overlap in progress when `rst_n` is asserted is discarded and does not commit after reset.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| hi_be_n | input | 1 | Upper byte lane enable (bits 15:8), active low |
| lo_be_n | input | 1 | Lower byte lane enable (bits 7:0), active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on lanes that are not driven |
| rdata_en | output | 2 | Per-lane drive enable: bit 0 for the lower lane, bit 1 for the upper lane |

## Verification
The assertions assume that the controls change only between sampling edges and that reset is held long enough for the internal synchronizer to settle. Under those conditions a commit can only follow a sampled overlap and can never coincide with one. The directed stimulus changes every input on the falling clock edge and keeps all controls idle while reset is released. It writes every location before any read, so no check depends on the undefined power-up contents. Stimulus that ends an overlap also changes the address and data in the same cycle, so a design that captured the wrong cycle would show it.

// File: rtl/bml_pkg.sv
package bml_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic [1:0] {
    MODE_DESEL  = 2'd0,
    MODE_READ   = 2'd1,
    MODE_OUTOFF = 2'd2,
    MODE_WRITE  = 2'd3
  } bml_mode_e;
endpackage

// File: rtl/bml_decode.sv
module bml_decode
  import bml_pkg::*;
(
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_be_n,
  output bml_mode_e        mode,
  output logic             wr_active,
  output logic [LANES-1:0] lane_drv,
  output logic [LANES-1:0] lane_wr
);
  // Mode priority: deselect beats write, write beats read.
  always_comb begin
    if (cs_n || (&lane_be_n)) mode = MODE_DESEL;
    else if (!we_n)           mode = MODE_WRITE;
    else if (!oe_n)           mode = MODE_READ;
    else                      mode = MODE_OUTOFF;
  end

  assign wr_active = (mode == MODE_WRITE);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_drv[g] = (mode == MODE_READ) && !lane_be_n[g];
    assign lane_wr[g]  = wr_active && !lane_be_n[g];
  end
endmodule

// File: rtl/bml_wtrack.sv
module bml_wtrack
  import bml_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovl_now,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_wr,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data,
  output logic [LANES-1:0]  c_mask
);
  logic              ovl_q, ovl_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [LANES-1:0]  mask_q, mask_d;

  always_comb begin
    ovl_d  = ovl_now;
    addr_d = addr_q;
    data_d = data_q;
    mask_d = mask_q;
    if (ovl_now) begin
      addr_d = addr;
      data_d = wdata;
      mask_d = lane_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovl_q <= 1'b0;
    else        ovl_q <= ovl_d;
  end

  // Payload holding registers: no reset, loaded only during the overlap.
  always_ff @(posedge clk) begin
    if (ovl_now) begin
      addr_q <= addr_d;
      data_q <= data_d;
      mask_q <= mask_d;
    end
  end

  assign commit = ovl_q && !ovl_now;
  assign c_addr = addr_q;
  assign c_data = data_q;
  assign c_mask = mask_q;
endmodule

// File: rtl/bml_store.sv
module bml_store
  import bml_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wmask,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/bml_top.sv
module bml_top
  import bml_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic                    hi_be_n,
  input  logic                    lo_be_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rdata_en
);
  localparam int unsigned DATA_W = LANES * LANE_W;

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  bml_mode_e         mode;
  logic              wr_active;
  logic [LANES-1:0]  lane_drv;
  logic [LANES-1:0]  lane_wr;
  logic              wr_commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;
  logic [LANES-1:0]  c_mask;
  logic [DATA_W-1:0] word;

  bml_decode u_dec (
    .cs_n      (cs_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .lane_be_n ({hi_be_n, lo_be_n}),
    .mode      (mode),
    .wr_active (wr_active),
    .lane_drv  (lane_drv),
    .lane_wr   (lane_wr)
  );

  bml_wtrack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .ovl_now (wr_active),
    .addr    (addr),
    .wdata   (wdata),
    .lane_wr (lane_wr),
    .commit  (wr_commit),
    .c_addr  (c_addr),
    .c_data  (c_data),
    .c_mask  (c_mask)
  );

  bml_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_st (
    .clk   (clk),
    .we    (wr_commit),
    .waddr (c_addr),
    .wdata (c_data),
    .wmask (c_mask),
    .raddr (addr),
    .rdata (word)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign rdata[g*LANE_W +: LANE_W] = lane_drv[g] ? word[g*LANE_W +: LANE_W] : '0;
  end
  assign rdata_en = lane_drv;
endmodule

// File: rtl/bml_checker.sv
module bml_checker #(
  parameter int unsigned LANE_W = 8
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              hi_be_n,
  input logic              lo_be_n,
  input logic [2*LANE_W-1:0] rdata,
  input logic [1:0]        rdata_en,
  input logic              wr_commit
);
  logic ovl_pins;
  assign ovl_pins = !cs_n && !we_n && !(hi_be_n && lo_be_n);

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cs_n || (hi_be_n && lo_be_n)) |-> (rdata_en == 2'b00));

  assert_read_lanes_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cs_n && we_n && !oe_n) |-> (rdata_en == {!hi_be_n, !lo_be_n}));

  assert_outoff_quiet_R3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cs_n && we_n && oe_n) |-> (rdata_en == 2'b00));

  assert_write_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cs_n && !we_n) |-> (rdata_en == 2'b00));

  assert_commit_after_overlap_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_commit |-> ($past(ovl_pins) && !ovl_pins));

  assert_idle_lane_zero_lo_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rdata_en[0] |-> (rdata[LANE_W-1:0] == '0));

  assert_idle_lane_zero_hi_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !rdata_en[1] |-> (rdata[2*LANE_W-1:LANE_W] == '0));
endmodule

bind bml_top bml_checker #(.LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .cs_n      (cs_n),
  .we_n      (we_n),
  .oe_n      (oe_n),
  .hi_be_n   (hi_be_n),
  .lo_be_n   (lo_be_n),
  .rdata     (rdata),
  .rdata_en  (rdata_en),
  .wr_commit (wr_commit)
);

// File: tb/bml_top_tb.sv
module bml_top_tb;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cs_n, we_n, oe_n, hi_be_n, lo_be_n;
  logic [AW-1:0] addr;
  logic [15:0]   wdata;
  logic [15:0]   rdata;
  logic [1:0]    rdata_en;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  logic [15:0] mdl [DEPTH];

  always #4 clk = ~clk;

  bml_top #(.ADDR_W(AW), .LANE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .hi_be_n(hi_be_n), .lo_be_n(lo_be_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: got %0d cycles, expected under 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk = n_chk + 1;
    if (got !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic set_bus(input logic c, input logic w, input logic o,
                         input logic hb, input logic lb,
                         input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; hi_be_n = hb; lo_be_n = lb; addr = a; wdata = d;
  endtask

  task automatic idle();
    set_bus(1, 1, 1, 1, 1, '0, 16'h0);
  endtask

  // Write overlap for one cycle, then end it by method term
  // (0: we_n rises, 1: cs_n rises, 2: both byte enables rise).
  // Address and data are scrambled in the terminating cycle (R6).
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                    input logic hb, input logic lb, input logic o, input int term);
    set_bus(0, 0, o, hb, lb, a, d);
    #2 chk("R4 bus not driven during write", {14'h0, rdata_en}, 16'h0);
    case (term)
      0:       set_bus(0, 1, 1, hb, lb, a ^ 6'h15, ~d);
      1:       set_bus(1, 0, 1, hb, lb, a ^ 6'h15, ~d);
      default: set_bus(0, 0, 1, 1, 1, a ^ 6'h15, ~d);
    endcase
    if (!lb) mdl[a][7:0]  = d[7:0];
    if (!hb) mdl[a][15:8] = d[15:8];
    idle();
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic hb, input logic lb);
    logic [15:0] exp;
    set_bus(0, 1, 0, hb, lb, a, 16'hDEAD);
    #2;
    exp = {(hb ? 8'h00 : mdl[a][15:8]), (lb ? 8'h00 : mdl[a][7:0])};
    chk({tag, " en"}, {14'h0, rdata_en}, {14'h0, !hb, !lb});
    chk({tag, " data"}, rdata, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cs_n = 1; we_n = 1; oe_n = 0; hi_be_n = 0; lo_be_n = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset deselected no drive", {14'h0, rdata_en}, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++)
      wr(i[AW-1:0], 16'hA5C3 ^ (i[15:0] * 16'h0101 + i[15:0]), 0, 0, 1, 0);
    for (int i = 0; i < DEPTH; i++) rd("R5 R2 fill readback", i[AW-1:0], 0, 0);
  endtask

  task automatic t_terminators();
    wr(6'd5, 16'h1357, 0, 0, 1, 1);
    rd("R5 ended by cs_n", 6'd5, 0, 0);
    wr(6'd6, 16'h2468, 0, 0, 0, 2);
    rd("R5 ended by byte enables, oe low", 6'd6, 0, 0);
    wr(6'd4, 16'h0F0F, 0, 0, 0, 0);
    rd("R5 ended by we_n, oe low", 6'd4, 0, 0);
  endtask

  task automatic t_lanes();
    wr(6'd7, 16'hBEEF, 1, 0, 1, 0);
    rd("R7 low lane only written", 6'd7, 0, 0);
    wr(6'd8, 16'hCAFE, 0, 1, 1, 1);
    rd("R7 high lane only written", 6'd8, 0, 0);
    rd("R2 R8 low lane read", 6'd9, 1, 0);
    rd("R2 R8 high lane read", 6'd9, 0, 1);
  endtask

  task automatic t_quiet();
    set_bus(1, 1, 0, 0, 0, 6'd3, 16'h0);
    #2 chk("R1 cs_n high", {14'h0, rdata_en}, 16'h0);
    chk("R8 cs_n high data", rdata, 16'h0);
    set_bus(0, 1, 0, 1, 1, 6'd3, 16'h0);
    #2 chk("R1 both byte enables high", {14'h0, rdata_en}, 16'h0);
    set_bus(0, 1, 1, 0, 0, 6'd3, 16'h0);
    #2 chk("R3 output gate high", {14'h0, rdata_en}, 16'h0);
    chk("R8 output gate high data", rdata, 16'h0);
    idle();
    rd("R1 R3 no write side effect", 6'd3, 0, 0);
  endtask

  task automatic t_last_cycle();
    // Address moves during a long overlap: only the last one is written.
    set_bus(0, 0, 1, 0, 0, 6'd10, 16'h1111);
    set_bus(0, 0, 1, 1, 0, 6'd11, 16'h2222);
    set_bus(0, 1, 1, 0, 0, 6'd12, 16'h3333);
    mdl[11][7:0] = 8'h22;
    idle();
    rd("R6 earlier overlap address untouched", 6'd10, 0, 0);
    rd("R6 last overlap address written", 6'd11, 0, 0);
    rd("R6 terminating address untouched", 6'd12, 0, 0);
    // Lane mask narrows in the last cycle: only the high lane changes.
    set_bus(0, 0, 1, 0, 0, 6'd13, 16'h4444);
    set_bus(0, 0, 1, 0, 1, 6'd13, 16'h5555);
    set_bus(1, 1, 1, 0, 0, 6'd13, 16'h6666);
    mdl[13][15:8] = 8'h55;
    idle();
    rd("R6 R7 last lane mask and data", 6'd13, 0, 0);
  endtask

  task automatic t_reset_abort();
    set_bus(0, 0, 1, 0, 0, 6'd14, 16'h7777);
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd("R9 write cut by reset discarded", 6'd14, 0, 0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_terminators();
    t_lanes();
    t_quiet();
    t_last_cycle();
    t_reset_abort();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule